// File: doc/BRIEF.md
# Dual-Width ROM Read Interface

This block models the read side of a read-only array that can present its contents either as 16-bit words or as 8-bit bytes. A width-select input picks the organisation. In word organisation all sixteen data lines carry the addressed word. In byte organisation the top data line is no longer an output: its input side becomes an extra, least significant address bit. That bit picks the low or high half of the addressed word, which is returned on the bottom eight lines.

Two active-low controls gate the outputs. The chip enable selects the device: when it is high the block is in standby. The output enable gates data onto the pins. Every data line has its own drive enable, so a pad ring can build a tri-state bus from `dq_out` and `dq_oe`. An identification mode, flagged by a separate input, replaces the array data with one of two fixed codes chosen by address bit 0. This lets programming equipment recognise the part.

The array contents are filled at elaboration from a parameterised formula. A parameter chooses whether the outputs are registered on the clock or follow the inputs combinationally.

Top module: `dwrom_read`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `id_mode`=0 and `wide_sel`=1, `dq_out` equals the whole 16-bit word at `addr` and `dq_oe` is 16'hFFFF.
- R2: With `ce_n`=0, `oe_n`=0, `id_mode`=0 and `wide_sel`=0, `dq_out[7:0]` is bits 7:0 of the word at `addr` when `byte_lsb`=0, and bits 15:8 when `byte_lsb`=1. `dq_oe` is 16'h00FF, so lines 8 to 15 are undriven and line 15 serves as the address input.
- R3: In word organisation the value of `byte_lsb` has no effect on `dq_out` or `dq_oe`.
- R4: With `ce_n`=1 (standby), `dq_oe` is 0 whatever `oe_n`, `id_mode`, `wide_sel` and `addr` are.
- R5: With `ce_n`=0 and `oe_n`=1 (output disable), `dq_oe` is 0.
- R6: With `ce_n`=0, `oe_n`=0 and `id_mode`=1, `dq_out` is 16'h0020 when `addr[0]`=0 and 16'h00B1 when `addr[0]`=1, and `dq_oe` is 16'hFFFF in either width. This mode takes priority over an array read.
- R7: The word stored at index i is ((i * MULT) mod 2^16) XOR SEED, with default MULT = 16'h9E37 and SEED = 16'h5A3C.
- R8: With REG_OUT=1 (the default), `dq_out` and `dq_oe` reflect the inputs sampled at the previous rising clock edge and hold between edges. With REG_OUT=0 they follow the inputs without a clock.
- R9: Every bit of `dq_out` whose drive enable is 0 reads 0. While `rst_n` is low at a rising edge, the registered outputs become all zero.
- R10: In identification mode only `addr[0]` selects the code. The other address bits, `byte_lsb` and `wide_sel` do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| byte_lsb | input | 1 | Input side of the shared top line; selects the byte half in byte organisation |
| wide_sel | input | 1 | 1 selects word organisation, 0 selects byte organisation |
| ce_n | input | 1 | Active-low chip enable; high puts the block in standby |
| oe_n | input | 1 | Active-low output enable |
| id_mode | input | 1 | Selects the identification codes instead of the array |
| dq_out | output | 16 | Data lines |
| dq_oe | output | 16 | Per-line drive enables |

## Verification
The hardest situation to reach from the ports is a clash of modes on the same cycle. Examples are identification mode requested while in standby or output disable, or byte organisation with identification asserted and high address bits set. Only the fixed order of precedence decides the result in such cases. The stimulus therefore sweeps all 32 combinations of the five mode inputs at several addresses, including the lowest and highest. Each combination is scored against a model that applies the precedence directly. A separate phase changes the address between clock edges to show that the registered outputs wait for the edge.

// File: rtl/dwrom_pkg.sv
// Package: shared constants, mode type and array fill function for the
// dual-width ROM read interface. Assumes a 16-bit word split in two bytes.
package dwrom_pkg;
    localparam int DQ_W   = 16;
    localparam int BYTE_W = DQ_W / 2;

    localparam logic [BYTE_W-1:0] ID_MAKER_CODE = 8'h20;
    localparam logic [BYTE_W-1:0] ID_PART_CODE  = 8'hB1;

    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_DISABLE = 3'd1,
        MD_WORD    = 3'd2,
        MD_BYTE    = 3'd3,
        MD_IDENT   = 3'd4
    } rd_mode_t;

    // Content of array entry idx: low 16 bits of idx*mult, xor seed.
    function automatic logic [DQ_W-1:0] fill_word(input int unsigned idx,
                                                  input logic [DQ_W-1:0] mult,
                                                  input logic [DQ_W-1:0] seed);
        logic [31:0] prod;
        prod = idx * {16'h0, mult};
        return prod[DQ_W-1:0] ^ seed;
    endfunction
endpackage

// File: rtl/dwrom_array.sv
// Read-only word array. Filled once at elaboration from fill_word;
// read is asynchronous. Assumes 2**ADDR_W entries stay small.
module dwrom_array
    import dwrom_pkg::*;
#(
    parameter int               ADDR_W = 8,
    parameter logic [DQ_W-1:0]  MULT   = 16'h9E37,
    parameter logic [DQ_W-1:0]  SEED   = 16'h5A3C
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DQ_W-1:0]   rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DQ_W-1:0] store [DEPTH];

    // Fill the array from the parameterised formula.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            store[i] = fill_word(i, MULT, SEED);
        end
    end

    // Asynchronous word read.
    assign rd_word = store[rd_addr];
endmodule

// File: rtl/dwrom_mode_dec.sv
// Decodes the control inputs into one read mode. Precedence:
// standby, then output disable, then identification, then width.
module dwrom_mode_dec
    import dwrom_pkg::*;
(
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     id_mode,
    input  logic     wide_sel,
    output rd_mode_t mode
);
    // Priority decode of the control lines.
    always_comb begin
        if (ce_n)          mode = MD_STANDBY;
        else if (oe_n)     mode = MD_DISABLE;
        else if (id_mode)  mode = MD_IDENT;
        else if (wide_sel) mode = MD_WORD;
        else               mode = MD_BYTE;
    end
endmodule

// File: rtl/dwrom_lane_mux.sv
// Builds the data lines and per-line drive enables for one mode.
// Undriven lines are forced to zero. Assumes DQ_W = 2*BYTE_W.
module dwrom_lane_mux
    import dwrom_pkg::*;
(
    input  rd_mode_t         mode,
    input  logic [DQ_W-1:0]  word,
    input  logic             byte_lsb,
    input  logic             addr_b0,
    output logic [DQ_W-1:0]  lane_dq,
    output logic [DQ_W-1:0]  lane_oe
);
    logic [BYTE_W-1:0] half_sel;
    logic [BYTE_W-1:0] id_code;

    // Pick the byte half named by the shared line.
    assign half_sel = byte_lsb ? word[DQ_W-1:BYTE_W] : word[BYTE_W-1:0];
    // Pick the identification code by address bit 0.
    assign id_code  = addr_b0 ? ID_PART_CODE : ID_MAKER_CODE;

    // Steer data and enables per mode.
    always_comb begin
        lane_dq = '0;
        lane_oe = '0;
        unique case (mode)
            MD_WORD: begin
                lane_dq = word;
                lane_oe = '1;
            end
            MD_BYTE: begin
                lane_dq = {{BYTE_W{1'b0}}, half_sel};
                lane_oe = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
            end
            MD_IDENT: begin
                lane_dq = {{BYTE_W{1'b0}}, id_code};
                lane_oe = '1;
            end
            default: begin
                lane_dq = '0;
                lane_oe = '0;
            end
        endcase
    end
endmodule

// File: rtl/dwrom_read.sv
// Top: dual-width ROM read interface. Array, mode decode and lane steering,
// with an optional output register (REG_OUT). Synchronous active-low reset.
module dwrom_read
    import dwrom_pkg::*;
#(
    parameter int               ADDR_W  = 8,
    parameter bit               REG_OUT = 1'b1,
    parameter logic [DQ_W-1:0]  MULT    = 16'h9E37,
    parameter logic [DQ_W-1:0]  SEED    = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_lsb,
    input  logic              wide_sel,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              id_mode,
    output logic [DQ_W-1:0]   dq_out,
    output logic [DQ_W-1:0]   dq_oe
);
    logic [DQ_W-1:0] arr_word;
    rd_mode_t        mode;
    logic [DQ_W-1:0] nxt_dq;
    logic [DQ_W-1:0] nxt_oe;

    dwrom_array #(.ADDR_W(ADDR_W), .MULT(MULT), .SEED(SEED)) u_array (
        .rd_addr (addr),
        .rd_word (arr_word)
    );

    dwrom_mode_dec u_dec (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .id_mode  (id_mode),
        .wide_sel (wide_sel),
        .mode     (mode)
    );

    dwrom_lane_mux u_mux (
        .mode     (mode),
        .word     (arr_word),
        .byte_lsb (byte_lsb),
        .addr_b0  (addr[0]),
        .lane_dq  (nxt_dq),
        .lane_oe  (nxt_oe)
    );

    generate
        if (REG_OUT) begin : g_reg
            // Register the lanes on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dq_out <= '0;
                    dq_oe  <= '0;
                end else begin
                    dq_out <= nxt_dq;
                    dq_oe  <= nxt_oe;
                end
            end
        end else begin : g_comb
            assign dq_out = nxt_dq;
            assign dq_oe  = nxt_oe;
        end
    endgenerate

    // Standby releases every line.
    p_standby_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> nxt_oe == '0);
    // Output disable releases every line.
    p_outdis_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |-> nxt_oe == '0);
    // Word read drives all sixteen lines with the array word.
    p_word_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !id_mode && wide_sel) |-> (nxt_oe == '1 && nxt_dq == arr_word));
    // Byte read drives only the low half.
    p_byte_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !id_mode && !wide_sel) |-> nxt_oe == 16'h00FF);
    // Identification codes beat the array.
    p_ident_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && id_mode) |->
        (nxt_dq == {8'h00, (addr[0] ? ID_PART_CODE : ID_MAKER_CODE)} && nxt_oe == '1));
    // Released lines read zero.
    p_hiz_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_dq & ~nxt_oe) == '0);
endmodule

// File: tb/dwrom_read_bench.sv
module dwrom_read_bench;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          byte_lsb = 1'b0;
    logic          wide_sel = 1'b1;
    logic          ce_n = 1'b0;
    logic          oe_n = 1'b0;
    logic          id_mode = 1'b0;
    logic [15:0]   dq_out;
    logic [15:0]   dq_oe;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;

    typedef struct {
        logic [15:0] dq;
        logic [15:0] oe;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    dwrom_read u_dwrom_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .byte_lsb (byte_lsb),
        .wide_sel (wide_sel),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .id_mode  (id_mode),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    // R7 content formula, written from the requirement.
    function automatic logic [15:0] content(input int unsigned a);
        logic [31:0] p;
        p = a * 32'h9E37;
        return p[15:0] ^ 16'h5A3C;
    endfunction

    function automatic exp_t model(input logic [AW-1:0] a, input logic lsb,
                                   input logic w, input logic ce, input logic oe,
                                   input logic id);
        exp_t e;
        logic [15:0] wd;
        wd = content(a);
        if (ce) begin
            e.dq = '0; e.oe = '0; e.tag = "R4 R9";
        end else if (oe) begin
            e.dq = '0; e.oe = '0; e.tag = "R5 R9";
        end else if (id) begin
            e.dq = {8'h00, (a[0] ? 8'hB1 : 8'h20)}; e.oe = 16'hFFFF; e.tag = "R6 R10";
        end else if (w) begin
            e.dq = wd; e.oe = 16'hFFFF; e.tag = "R1 R3 R7";
        end else begin
            e.dq = {8'h00, (lsb ? wd[15:8] : wd[7:0])}; e.oe = 16'h00FF; e.tag = "R2 R7";
        end
        return e;
    endfunction

    task automatic check(input string tag, input logic [15:0] got_dq, input logic [15:0] got_oe,
                         input logic [15:0] e_dq, input logic [15:0] e_oe);
        checks++;
        if (got_dq !== e_dq || got_oe !== e_oe) begin
            errors++;
            $display("FAIL %s dq=%h oe=%h expected dq=%h oe=%h", tag, got_dq, got_oe, e_dq, e_oe);
        end
    endtask

    // Driver: apply one stimulus at a falling edge and push its expectation.
    task automatic drive(input logic [AW-1:0] a, input logic lsb, input logic w,
                         input logic ce, input logic oe, input logic id);
        @(negedge clk);
        addr = a; byte_lsb = lsb; wide_sel = w; ce_n = ce; oe_n = oe; id_mode = id;
        exp_q.push_back(model(a, lsb, w, ce, oe, id));
    endtask

    // Monitor: after each rising edge, compare the oldest expectation.
    always @(posedge clk) begin
        #1;
        if (mon_on && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, dq_out, dq_oe, e.dq, e.oe);
        end
    end

    initial begin
        logic [AW-1:0] pick [6];
        pick[0] = 8'h00; pick[1] = 8'hFF; pick[2] = 8'h01;
        pick[3] = 8'h5A; pick[4] = 8'hA7; pick[5] = 8'h80;

        // R9: reset clears registered outputs even with a word read requested.
        repeat (2) @(posedge clk);
        #1;
        check("R9 reset", dq_out, dq_oe, 16'h0000, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // All 32 mode-input combinations at several addresses (R1..R7, R10).
        for (int k = 0; k < 6; k++) begin
            for (int m = 0; m < 32; m++) begin
                drive(pick[k], m[0], m[1], m[2], m[3], m[4]);
            end
        end
        @(negedge clk);
        repeat (2) @(posedge clk);
        mon_on = 1'b0;
        #2;

        // R8: registered outputs wait for the clock edge.
        @(negedge clk);
        addr = 8'h05; wide_sel = 1'b1; ce_n = 1'b0; oe_n = 1'b0; id_mode = 1'b0;
        @(posedge clk); #1;
        check("R8 R1 after edge", dq_out, dq_oe, content(5), 16'hFFFF);
        @(negedge clk);
        addr = 8'h06;
        #1;
        check("R8 hold between edges", dq_out, dq_oe, content(5), 16'hFFFF);
        @(posedge clk); #1;
        check("R8 R7 next edge", dq_out, dq_oe, content(6), 16'hFFFF);

        // R3: flipping byte_lsb in word mode has no effect.
        @(negedge clk);
        byte_lsb = ~byte_lsb;
        @(posedge clk); #1;
        check("R3 lsb ignored", dq_out, dq_oe, content(6), 16'hFFFF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule